// File: doc/BRIEF.md
# Dual-Channel Serial DAC Command Front End

This block is the digital side of a two-channel, 10-bit voltage-output converter. A host shifts a 16-bit command word in over a three-wire serial link: an active-low chip-select/load line, a serial clock and a data line. The word carries a 4-bit opcode, a 10-bit code and two padding bits. When chip select returns high after a complete word, the opcode is carried out. It can load the pending code of one or both channels, move pending codes to the converter registers, or enter or leave a low-power sleep state.

Each channel holds two registers. An input register keeps a pending code. A DAC register drives the converter. Because both DAC registers can be written in the same cycle, both outputs change together. Every pin is sampled by a single system clock through two-flop synchronizers, so that clock must run at least four times faster than the serial clock.

Top module: `dual_dac_frontend`

## Requirements
- R1: The word is sent MSB first. Bits 1 to 4 are the opcode (bit 1 is its MSB). Bits 5 to 14 are the code (bit 5 is its MSB). Bits 15 and 16 have no effect.
- R2: A data bit is taken only on a rising serial clock edge while chip select is low. Clock edges while chip select is high have no effect.
- R3: Outputs do not change before chip select rises. They settle within a few system clocks after it rises.
- R4: Opcode 0001 loads input A, 0010 loads input B and 1111 loads both. None of them changes a DAC output.
- R5: Opcode 1000 copies both input registers into the DAC registers in the same cycle.
- R6: Opcodes 1001, 1010 and 1100 load input A, input B, or both with the code, then update both DAC registers. A channel just loaded takes the new code.
- R7: Opcode 1110 sets the sleep flag and leaves both DAC values unchanged. Opcode 1101 clears the sleep flag.
- R8: Any opcode that updates the DAC registers also clears the sleep flag.
- R9: Opcode 0000 and every opcode not listed above have no effect.
- R10: If chip select rises after any bit count other than 16, the frame is discarded. No register and no sleep state changes.
- R11: After reset, both DAC outputs and both input registers are zero, sleep is clear and both enables are high.
- R12: Both channel enables are high exactly when the sleep flag is clear.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rstN | input | 1 | Active-low asynchronous reset |
| csLdN | input | 1 | Chip select, active low; its rising edge executes the frame |
| sclk | input | 1 | Serial clock |
| sdi | input | 1 | Serial data in |
| dacCodeA | output | 10 | DAC register of channel A |
| dacCodeB | output | 10 | DAC register of channel B |
| sleepOn | output | 1 | Sleep flag |
| enA | output | 1 | Channel A enable |
| enB | output | 1 | Channel B enable |

## Verification
A wrong input register is not visible when it is loaded. It shows up only at the next update, as a wrong DAC value, so every opcode in the sweep is followed by a plain update frame. A miscount in the bit counter or the shift register shows up as a wrong or missing change on the DAC outputs within a few clocks of chip select rising, or as a discarded frame that still changes something. A stuck sleep flag shows up at once on the enables, and again after the next update.

// File: rtl/dacif_pkg.sv
package dacif_pkg;
  parameter int CODE_W = 10;
  parameter int CTRL_W = 4;
  parameter int PAD_W  = 2;
  parameter int NUM_CH = 2;
  localparam int FRAME_W = CTRL_W + CODE_W + PAD_W;

  typedef enum logic [CTRL_W-1:0] {
    OP_NOP       = 4'b0000,
    OP_LD_A      = 4'b0001,
    OP_LD_B      = 4'b0010,
    OP_UPD       = 4'b1000,
    OP_LD_A_UPD  = 4'b1001,
    OP_LD_B_UPD  = 4'b1010,
    OP_LD_AB_UPD = 4'b1100,
    OP_WAKE      = 4'b1101,
    OP_SLEEP     = 4'b1110,
    OP_LD_AB     = 4'b1111
  } dacOp_t;

  // load[0] is channel A, load[1] is channel B
  typedef struct packed {
    logic              fire;
    logic [NUM_CH-1:0] load;
    logic              update;
    logic              goSleep;
    logic              goWake;
    logic [CODE_W-1:0] code;
  } dacStrobe_t;
endpackage

// File: rtl/dacif_ctrl.sv
module dacif_ctrl
  import dacif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic       clk,
  input  logic       rstN,
  input  logic       csLdN,
  input  logic       sclk,
  input  logic       sdi,
  output dacStrobe_t strb
);
  localparam int CNT_W   = $clog2(FRAME_W + 2);
  localparam int CNT_MAX = FRAME_W + 1;

  logic [SYNC_STAGES:0]   sckSh;
  logic [SYNC_STAGES:0]   csSh;
  logic [SYNC_STAGES-1:0] sdiSh;
  logic [CNT_W-1:0]       bitCnt;
  logic [FRAME_W-1:0]     shReg;
  logic sckRise, csRise, csLow, frameFull;
  dacOp_t op;

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      sckSh <= '0;
      csSh  <= '1;
      sdiSh <= '0;
    end else begin
      sckSh <= {sckSh[SYNC_STAGES-1:0], sclk};
      csSh  <= {csSh[SYNC_STAGES-1:0], csLdN};
      sdiSh <= {sdiSh[SYNC_STAGES-2:0], sdi};
    end
  end

  assign sckRise = sckSh[SYNC_STAGES-1] & ~sckSh[SYNC_STAGES];
  assign csRise  = csSh[SYNC_STAGES-1] & ~csSh[SYNC_STAGES];
  assign csLow   = ~csSh[SYNC_STAGES-1];

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN) begin
      bitCnt <= '0;
      shReg  <= '0;
    end else if (!csLow) begin
      bitCnt <= '0;
    end else if (sckRise) begin
      shReg <= {shReg[FRAME_W-2:0], sdiSh[SYNC_STAGES-1]};
      if (bitCnt != CNT_W'(CNT_MAX)) bitCnt <= bitCnt + 1'b1;
    end
  end

  assign frameFull = (bitCnt == CNT_W'(FRAME_W));
  assign op = dacOp_t'(shReg[FRAME_W-1 -: CTRL_W]);

  always_comb begin
    strb      = '0;
    strb.code = shReg[FRAME_W-1-CTRL_W -: CODE_W];
    if (csRise && frameFull) begin
      strb.fire = 1'b1;
      case (op)
        OP_LD_A:      strb.load = 2'b01;
        OP_LD_B:      strb.load = 2'b10;
        OP_LD_AB:     strb.load = 2'b11;
        OP_UPD:       strb.update = 1'b1;
        OP_LD_A_UPD:  begin strb.load = 2'b01; strb.update = 1'b1; end
        OP_LD_B_UPD:  begin strb.load = 2'b10; strb.update = 1'b1; end
        OP_LD_AB_UPD: begin strb.load = 2'b11; strb.update = 1'b1; end
        OP_WAKE:      strb.goWake = 1'b1;
        OP_SLEEP:     strb.goSleep = 1'b1;
        default:      ;
      endcase
    end
  end
endmodule

// File: rtl/dacif_datapath.sv
module dacif_datapath
  import dacif_pkg::*;
(
  input  logic                           clk,
  input  logic                           rstN,
  input  dacStrobe_t                     strb,
  output logic [NUM_CH-1:0][CODE_W-1:0]  dacReg,
  output logic                           sleepReg,
  output logic [NUM_CH-1:0]              chanEn
);
  logic [NUM_CH-1:0][CODE_W-1:0] inReg;

  for (genvar g = 0; g < NUM_CH; g++) begin : g_chan
    always_ff @(posedge clk or negedge rstN) begin
      if (!rstN) begin
        inReg[g]  <= '0;
        dacReg[g] <= '0;
      end else begin
        if (strb.load[g]) inReg[g] <= strb.code;
        if (strb.update)  dacReg[g] <= strb.load[g] ? strb.code : inReg[g];
      end
    end
  end

  always_ff @(posedge clk or negedge rstN) begin
    if (!rstN)                            sleepReg <= 1'b0;
    else if (strb.goSleep)                sleepReg <= 1'b1;
    else if (strb.update || strb.goWake)  sleepReg <= 1'b0;
  end

  assign chanEn = {NUM_CH{~sleepReg}};
endmodule

// File: rtl/dual_dac_frontend.sv
module dual_dac_frontend
  import dacif_pkg::*;
#(
  parameter int SYNC_STAGES = 2
) (
  input  logic              clk,
  input  logic              rstN,
  input  logic              csLdN,
  input  logic              sclk,
  input  logic              sdi,
  output logic [CODE_W-1:0] dacCodeA,
  output logic [CODE_W-1:0] dacCodeB,
  output logic              sleepOn,
  output logic              enA,
  output logic              enB
);
  dacStrobe_t                    ctrlStrb;
  logic [NUM_CH-1:0][CODE_W-1:0] dacRegs;
  logic [NUM_CH-1:0]             chanEn;
  logic                          execFire;

  dacif_ctrl #(.SYNC_STAGES(SYNC_STAGES)) u_ctrl (
    .clk(clk), .rstN(rstN), .csLdN(csLdN), .sclk(sclk), .sdi(sdi), .strb(ctrlStrb)
  );

  dacif_datapath u_dp (
    .clk(clk), .rstN(rstN), .strb(ctrlStrb),
    .dacReg(dacRegs), .sleepReg(sleepOn), .chanEn(chanEn)
  );

  assign execFire = ctrlStrb.fire;
  assign dacCodeA = dacRegs[0];
  assign dacCodeB = dacRegs[1];
  assign enA      = chanEn[0];
  assign enB      = chanEn[1];
endmodule

// File: rtl/dacif_chk.sv
module dacif_chk
  import dacif_pkg::*;
(
  input logic              clk,
  input logic              rstN,
  input logic              fire,
  input logic [CODE_W-1:0] dacA,
  input logic [CODE_W-1:0] dacB,
  input logic              sleepOn,
  input logic              enA,
  input logic              enB
);
  // R3
  frame_commit_chk: assert property (@(posedge clk) disable iff (!rstN)
    !fire |=> ($stable(dacA) && $stable(dacB) && $stable(sleepOn)));

  // R7
  sleep_retain_chk: assert property (@(posedge clk) disable iff (!rstN)
    $rose(sleepOn) |-> ($stable(dacA) && $stable(dacB)));

  // R8
  update_wakes_chk: assert property (@(posedge clk) disable iff (!rstN)
    (!$stable(dacA) || !$stable(dacB)) |-> !sleepOn);

  // R12
  enable_follow_chk: assert property (@(posedge clk) disable iff (!rstN)
    ($fell(sleepOn) |-> (enA && enB)) and ($rose(sleepOn) |-> (!enA && !enB)));
endmodule

bind dual_dac_frontend dacif_chk u_chk (
  .clk(clk), .rstN(rstN), .fire(execFire),
  .dacA(dacCodeA), .dacB(dacCodeB), .sleepOn(sleepOn), .enA(enA), .enB(enB)
);

// File: tb/dual_dac_frontend_bench.sv
`timescale 1ns/1ps
module dual_dac_frontend_bench;
  logic clk = 1'b0, rstN = 1'b0, csLdN = 1'b1, sclk = 1'b0, sdi = 1'b0;
  logic [9:0] dacCodeA, dacCodeB;
  logic sleepOn, enA, enB;
  int testCnt = 0, failCnt = 0;
  logic [9:0] mInA = '0, mInB = '0, mDacA = '0, mDacB = '0;
  logic mSlp = 1'b0;

  always #5 clk = ~clk;

  dual_dac_frontend u_dual_dac_frontend (
    .clk(clk), .rstN(rstN), .csLdN(csLdN), .sclk(sclk), .sdi(sdi),
    .dacCodeA(dacCodeA), .dacCodeB(dacCodeB), .sleepOn(sleepOn), .enA(enA), .enB(enB)
  );

  task automatic checkState(input string req);
    testCnt++;
    if (dacCodeA !== mDacA || dacCodeB !== mDacB || sleepOn !== mSlp ||
        enA !== ~mSlp || enB !== ~mSlp) begin
      failCnt++;
      $display("FAIL %s: got A=%h B=%h slp=%b en=%b%b exp A=%h B=%h slp=%b en=%b%b",
               req, dacCodeA, dacCodeB, sleepOn, enA, enB,
               mDacA, mDacB, mSlp, ~mSlp, ~mSlp);
    end
  endtask

  task automatic modelApply(input logic [3:0] op, input logic [9:0] code);
    case (op)
      4'b0001: mInA = code;
      4'b0010: mInB = code;
      4'b1111: begin mInA = code; mInB = code; end
      4'b1000: begin mDacA = mInA; mDacB = mInB; mSlp = 1'b0; end
      4'b1001: begin mInA = code; mDacA = mInA; mDacB = mInB; mSlp = 1'b0; end
      4'b1010: begin mInB = code; mDacA = mInA; mDacB = mInB; mSlp = 1'b0; end
      4'b1100: begin mInA = code; mInB = code; mDacA = code; mDacB = code; mSlp = 1'b0; end
      4'b1101: mSlp = 1'b0;
      4'b1110: mSlp = 1'b1;
      default: ;
    endcase
  endtask

  function automatic string opTag(input logic [3:0] op);
    case (op)
      4'b0001, 4'b0010, 4'b1111: return "R4";
      4'b1000:                   return "R5";
      4'b1001, 4'b1010, 4'b1100: return "R6";
      4'b1101, 4'b1110:          return "R7";
      default:                   return "R9";
    endcase
  endfunction

  // Shifts nbits of {op, code, pad} MSB first; extra bits beyond 16 are ones.
  task automatic sendFrame(input logic [3:0] op, input logic [9:0] code,
                           input int nbits, input logic [1:0] pad);
    logic [15:0] w;
    w = {op, code, pad};
    csLdN = 1'b0;
    repeat (4) @(negedge clk);
    for (int i = 0; i < nbits; i++) begin
      sdi  = (i < 16) ? w[15-i] : 1'b1;
      sclk = 1'b0;
      repeat (4) @(negedge clk);
      sclk = 1'b1;
      repeat (4) @(negedge clk);
    end
    sclk = 1'b0;
    repeat (6) @(negedge clk);
    checkState("R3");
    csLdN = 1'b1;
    repeat (8) @(negedge clk);
  endtask

  initial begin
    #1_000_000;
    failCnt++;
    $display("FAIL watchdog: got timeout exp completion");
    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end

  initial begin
    logic [9:0] pats [4];
    logic [9:0] c;
    pats[0] = 10'h000; pats[1] = 10'h3FF; pats[2] = 10'h2AA; pats[3] = 10'h155;
    repeat (3) @(negedge clk);
    rstN = 1'b1;
    repeat (3) @(negedge clk);
    checkState("R11");

    // R2: clock toggles with chip select high carry no bits
    for (int i = 0; i < 9; i++) begin
      sdi = 1'b1; sclk = 1'b1; repeat (4) @(negedge clk);
      sclk = 1'b0; repeat (4) @(negedge clk);
    end
    sendFrame(4'b1100, 10'h2C5, 16, 2'b00);
    modelApply(4'b1100, 10'h2C5);
    checkState("R2");

    // R1: padding bits have no effect
    sendFrame(4'b1001, 10'h1A7, 16, 2'b11);
    modelApply(4'b1001, 10'h1A7);
    checkState("R1");
    sendFrame(4'b1010, 10'h0F3, 16, 2'b10);
    modelApply(4'b1010, 10'h0F3);
    checkState("R1");

    // Opcode sweep across code patterns, each followed by a plain update
    foreach (pats[p]) begin
      for (int op = 0; op < 16; op++) begin
        logic wasAsleep;
        c = pats[p] ^ 10'(op * 37);
        sendFrame(4'(op), c, 16, 2'b01);
        modelApply(4'(op), c);
        checkState(opTag(4'(op)));
        wasAsleep = mSlp;
        sendFrame(4'b1000, 10'h000, 16, 2'b00);
        modelApply(4'b1000, 10'h000);
        checkState(wasAsleep ? "R8" : "R5");
      end
    end

    // R7: sleep retains values, wake releases
    sendFrame(4'b1100, 10'h321, 16, 2'b00);
    modelApply(4'b1100, 10'h321);
    sendFrame(4'b1110, 10'h3FF, 16, 2'b00);
    modelApply(4'b1110, 10'h3FF);
    checkState("R7");
    sendFrame(4'b1101, 10'h000, 16, 2'b00);
    modelApply(4'b1101, 10'h000);
    checkState("R7");

    // R10: short and long frames are dropped, including a sleep command
    sendFrame(4'b1110, 10'h000, 15, 2'b00);
    checkState("R10");
    sendFrame(4'b1100, 10'h3C3, 15, 2'b00);
    checkState("R10");
    sendFrame(4'b1100, 10'h3C3, 17, 2'b00);
    checkState("R10");
    sendFrame(4'b0001, 10'h0AA, 1, 2'b00);
    checkState("R10");
    sendFrame(4'b1000, 10'h000, 16, 2'b00);
    modelApply(4'b1000, 10'h000);
    checkState("R10");

    $display("[TB] %0d tests run, %0d failed", testCnt, failCnt);
    $finish;
  end
endmodule